// File: doc/BRIEF.md
# Segment Line Scan Readout

This block turns the contents of a page-organised display memory into the 64 segment drive bits for the line that the panel is currently scanning. A line pointer moves once per line strobe. While the frame marker is high at a strobe, the pointer is loaded from a start-line value instead, so software can scroll the picture vertically by changing that value. The pointer wraps from the last line back to line 0.

During each line period the block reads one byte per column from memory. The page it reads is the pointer divided by 8, and it keeps the bit selected by the pointer modulo 8. At the next line strobe the assembled row goes into the segment output register. At that moment two further steps apply: an optional left-right mirror, and blanking when the display is switched off.

Reset is active low and asynchronous. It clears every segment output, the pointer and the row under assembly. The memory answers a read one cycle after the request. The block owns the read port while its fetch runs, so any host access has to be held off during those cycles.

Top module: `lcd_seg_scan`

## Requirements
- R1: While `rst_n` is low, `seg_out` is all zero. After reset is released, the line pointer is 0 and the row held for output is all zero.
- R2: On a clock edge with `line_tick` high and `frame_hi` high, the line pointer loads `start_line`.
- R3: On a clock edge with `line_tick` high and `frame_hi` low, the line pointer advances by one and wraps from 63 to 0.
- R4: For pointer z, column c of the row comes from bit (z mod 8) of the byte at page z/8, column c. A stored 1 makes the segment 1 (dot on) and a stored 0 makes it 0.
- R5: At a strobe with `col_order`=1, column c drives `seg_out[c]`. With `col_order`=0, column c drives `seg_out[63-c]`.
- R6: At a strobe with `disp_on`=0, `seg_out` becomes all zero whatever the memory holds.
- R7: `seg_out` changes only at a line strobe. A change of `disp_on` or `col_order` between strobes has no effect until the next strobe.
- R8: On the cycle after a strobe, a fetch starts with `rd_en` high. It issues exactly 64 reads on consecutive cycles, for columns 0 to 63 in rising order, at page z/8. `rd_en` stays low for the rest of the line. The row fetched for line z appears at the strobe that follows. The line period must therefore be at least 66 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; blanks the outputs |
| line_tick | input | 1 | Line strobe, one cycle wide |
| frame_hi | input | 1 | Frame marker; when high at a strobe, the pointer is preset |
| start_line | input | 6 | Scroll value loaded into the line pointer |
| disp_on | input | 1 | Display enable, sampled at each strobe |
| col_order | input | 1 | 1: straight column order, 0: mirrored |
| rd_en | output | 1 | Memory read request |
| rd_page | output | 3 | Memory page address |
| rd_col | output | 6 | Memory column address |
| rd_data | input | 8 | Memory read data, one cycle after the request |
| seg_out | output | 64 | Segment on/off vector |

## Verification
The memory is filled with random bytes, so every line and bit plane gives a different row. A wrong page, a wrong bit select or a stale row therefore shows up at the next strobe. Directed lines cover several cases: a preset at start line 63 followed by a plain advance, which separates a correct wrap from a wrong one; lines with the display off, which must blank a non-zero row; and mirrored lines, which separate the two column orders. Some lines flip the enable and mirror controls part-way through to show that the output holds until the next strobe. A reset in the middle of the run is also included. A random phase follows, with random scroll values, frame markers and control settings, and with the memory rewritten between lines.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
   parameter int SEG_N_DEF  = 64;
   parameter int LINE_N_DEF = 64;
   parameter int BYTE_W_DEF = 8;
endpackage

// File: rtl/lss_line_ctr.sv
module lss_line_ctr #(
   parameter int LINE_N = lcd_scan_pkg::LINE_N_DEF,
   localparam int ZW = $clog2(LINE_N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_tick,
   input  logic          frame_hi,
   input  logic [ZW-1:0] start_line,
   output logic [ZW-1:0] z
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         z <= '0;
      else if (line_tick)
         z <= frame_hi ? start_line : z + 1'b1;
   end

   a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && frame_hi |=> z == $past(start_line));
   a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && !frame_hi |=> z == ZW'($past(z) + 1'b1));
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !line_tick |=> $stable(z));
endmodule

// File: rtl/lss_row_fetch.sv
module lss_row_fetch #(
   parameter int SEG_N  = lcd_scan_pkg::SEG_N_DEF,
   parameter int LINE_N = lcd_scan_pkg::LINE_N_DEF,
   parameter int BYTE_W = lcd_scan_pkg::BYTE_W_DEF,
   localparam int ZW = $clog2(LINE_N),
   localparam int BW = $clog2(BYTE_W),
   localparam int PW = ZW - BW,
   localparam int CW = $clog2(SEG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic [ZW-1:0]     z,
   output logic              rd_en,
   output logic [PW-1:0]     rd_page,
   output logic [CW-1:0]     rd_col,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [SEG_N-1:0]  row
);
   logic          active;
   logic [CW-1:0] cnt;
   logic          vld_q;
   logic [CW-1:0] col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (line_tick) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (active) begin
         cnt <= cnt + 1'b1;
         if (cnt == CW'(SEG_N - 1))
            active <= 1'b0;
      end
   end

   assign rd_en   = active;
   assign rd_page = z[ZW-1:BW];
   assign rd_col  = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         col_q <= '0;
         row   <= '0;
      end else begin
         vld_q <= rd_en;
         col_q <= cnt;
         if (vld_q)
            row[col_q] <= rd_data[z[BW-1:0]];
      end
   end

   a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick |=> rd_en && rd_col == '0);
   a_r8_col_step: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !line_tick |=> !rd_en || rd_col == CW'($past(rd_col) + 1'b1));
   a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_col == CW'(SEG_N - 1) && !line_tick |=> !rd_en);
endmodule

// File: rtl/lss_seg_latch.sv
module lss_seg_latch #(
   parameter int SEG_N = lcd_scan_pkg::SEG_N_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_tick,
   input  logic             disp_on,
   input  logic             col_order,
   input  logic [SEG_N-1:0] row,
   output logic [SEG_N-1:0] seg
);
   logic [SEG_N-1:0] mapped;

   for (genvar i = 0; i < SEG_N; i++) begin : g_map
      assign mapped[i] = col_order ? row[i] : row[SEG_N-1-i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seg <= '0;
      else if (line_tick)
         seg <= disp_on ? mapped : '0;
   end

   a_r1_reset_blank: assert property (@(posedge clk)
      !rst_n |-> seg == '0);
   a_r6_off_blank: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && !disp_on |=> seg == '0);
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !line_tick |=> $stable(seg));
endmodule

// File: rtl/lcd_seg_scan.sv
module lcd_seg_scan #(
   parameter int SEG_N  = lcd_scan_pkg::SEG_N_DEF,
   parameter int LINE_N = lcd_scan_pkg::LINE_N_DEF,
   parameter int BYTE_W = lcd_scan_pkg::BYTE_W_DEF,
   localparam int ZW = $clog2(LINE_N),
   localparam int BW = $clog2(BYTE_W),
   localparam int PW = ZW - BW,
   localparam int CW = $clog2(SEG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic              frame_hi,
   input  logic [ZW-1:0]     start_line,
   input  logic              disp_on,
   input  logic              col_order,
   output logic              rd_en,
   output logic [PW-1:0]     rd_page,
   output logic [CW-1:0]     rd_col,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [SEG_N-1:0]  seg_out
);
   if ((1 << ZW) != LINE_N || (1 << BW) != BYTE_W || LINE_N < BYTE_W) begin : g_bad_geom
      $error("line count and byte width must be powers of two, lines >= byte width");
   end
   if ((1 << CW) != SEG_N) begin : g_bad_seg
      $error("segment count must be a power of two");
   end

   logic [ZW-1:0]    z;
   logic [SEG_N-1:0] row;

   lss_line_ctr #(.LINE_N(LINE_N)) u_ctr (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .frame_hi(frame_hi),
      .start_line(start_line), .z(z)
   );

   lss_row_fetch #(.SEG_N(SEG_N), .LINE_N(LINE_N), .BYTE_W(BYTE_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .z(z),
      .rd_en(rd_en), .rd_page(rd_page), .rd_col(rd_col), .rd_data(rd_data),
      .row(row)
   );

   lss_seg_latch #(.SEG_N(SEG_N)) u_latch (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .disp_on(disp_on),
      .col_order(col_order), .row(row), .seg(seg_out)
   );
endmodule

// File: tb/lcd_seg_scan_tb_top.sv
module lcd_seg_scan_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        line_tick = 1'b0;
   logic        frame_hi = 1'b0;
   logic [5:0]  start_line = '0;
   logic        disp_on = 1'b0;
   logic        col_order = 1'b1;
   logic        rd_en;
   logic [2:0]  rd_page;
   logic [5:0]  rd_col;
   logic [7:0]  rd_data;
   logic [63:0] seg_out;

   logic [7:0]  mem [0:511];
   int          rd_cnt;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;
   int          exp_z = 0;
   logic [63:0] exp_row = '0;
   logic [63:0] seg_exp = '0;
   bit          have_row = 1'b0;

   always #10 clk = ~clk;

   lcd_seg_scan dut_i (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .frame_hi(frame_hi),
      .start_line(start_line), .disp_on(disp_on), .col_order(col_order),
      .rd_en(rd_en), .rd_page(rd_page), .rd_col(rd_col), .rd_data(rd_data),
      .seg_out(seg_out)
   );

   always @(posedge clk) begin
      if (rd_en) rd_data <= mem[{rd_page, rd_col}];
      if (line_tick) rd_cnt <= 0;
      else if (rd_en) rd_cnt <= rd_cnt + 1;
   end

   function automatic logic [63:0] row_of(int z);
      logic [63:0] r;
      for (int c = 0; c < 64; c++) r[c] = mem[(z / 8) * 64 + c][z % 8];
      return r;
   endfunction

   function automatic logic [63:0] map_row(logic [63:0] r, logic straight);
      logic [63:0] s;
      for (int i = 0; i < 64; i++) s[i] = straight ? r[i] : r[63 - i];
      return s;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_line(bit frm, logic [5:0] st, bit on, bit straight, bit toggle_mid);
      @(negedge clk);
      if (have_row) check("R8 reads per line", 64'(rd_cnt), 64'd64);
      line_tick = 1'b1; frame_hi = frm; start_line = st;
      disp_on = on; col_order = straight;
      seg_exp = (have_row && on) ? map_row(exp_row, straight) : '0;
      exp_z = frm ? int'(st) : (exp_z + 1) % 64;
      @(negedge clk);
      line_tick = 1'b0;
      check(frm ? "R2 R4 R5 R6 preset line" : "R3 R4 R5 R6 next line", seg_out, seg_exp);
      exp_row = row_of(exp_z);
      have_row = 1'b1;
      repeat (10) @(negedge clk);
      if (toggle_mid) begin
         disp_on = ~disp_on; col_order = ~col_order;
         repeat (10) @(negedge clk);
         check("R7 hold between strobes", seg_out, seg_exp);
      end
      repeat (55) @(negedge clk);
      for (int k = 0; k < 4; k++) mem[$urandom_range(0, 511)] = 8'($urandom);
   endtask

   initial begin
      void'($urandom(32'h5c0a1));
      for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
      #2 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset blank", seg_out, '0);
      rst_n = 1'b1;
      // R1: first strobe after reset shows the cleared row
      do_line(1'b0, 6'd0, 1'b1, 1'b1, 1'b0);
      do_line(1'b1, 6'd5, 1'b1, 1'b1, 1'b0);
      do_line(1'b0, 6'd0, 1'b1, 1'b1, 1'b0);
      do_line(1'b1, 6'd63, 1'b1, 1'b1, 1'b0);
      do_line(1'b0, 6'd0, 1'b1, 1'b1, 1'b0);   // R3 wrap 63 -> 0
      do_line(1'b0, 6'd0, 1'b0, 1'b1, 1'b0);   // R6 off
      do_line(1'b0, 6'd0, 1'b1, 1'b0, 1'b0);   // R5 mirror
      do_line(1'b0, 6'd0, 1'b1, 1'b0, 1'b1);   // R7
      do_line(1'b0, 6'd0, 1'b0, 1'b1, 1'b1);   // R7 from off
      do_line(1'b1, 6'd42, 1'b1, 1'b0, 1'b0);
      // R1: mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run blank", seg_out, '0);
      rst_n = 1'b1;
      exp_z = 0; have_row = 1'b0; exp_row = '0;
      do_line(1'b0, 6'd0, 1'b1, 1'b1, 1'b0);
      do_line(1'b0, 6'd0, 1'b1, 1'b1, 1'b0);   // R1 pointer 0 after reset
      for (int n = 0; n < 48; n++)
         do_line(($urandom_range(0, 7) == 0), 6'($urandom), ($urandom_range(0, 3) != 0),
                 1'($urandom), ($urandom_range(0, 4) == 0));
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule